// File: doc/BRIEF.md
# Sixteen-Bit Up-Counter With Selectable Ceiling

This block is a free-running up-counter, 16 bits wide by default. It restarts from zero once it reaches a ceiling value, and a mode input chooses that ceiling. The ceiling can be one of three fixed values, the full counter range, the first compare register, or the capture register. Three compare channels each hold a value. A channel raises a sticky flag when the count equals its value, and in the waveform modes it drives a pulse-width output.

A digital trigger input, with an optional glitch filter, copies the running count into the capture register on the chosen edge. A single write port loads the three compare registers and the capture register.

When the first compare register sets the ceiling, writes to it go to a shadow copy. The shadow copy becomes active only when the count wraps, so the period can be changed while the counter runs without a glitch. When the capture register sets the ceiling, the first compare channel is free to act as a normal waveform channel.

Top module: `cntr_ceiling_timer`

## Requirements
- R1: While `rst` is high and after it falls, `count`, `capture`, `flags` and `pwm_out` read zero until the first clock edge with `rst` low.
- R2: Each clock edge adds one to `count`. When `count` is at or above the ceiling, the next edge loads zero instead. Mode 0 counts up to 0xFFFF before it wraps.
- R3: The ceiling depends on `mode`. Mode 1 uses 0x00FF, mode 2 uses 0x01FF and mode 3 uses 0x03FF. Modes 0, 6 and 7 count the full range.
- R4: Mode 4 uses compare register 0 as the ceiling. In this mode a write to that register is held aside and takes effect at the next wrap. `pwm_out[0]` stays low in this mode.
- R5: Mode 5 uses the capture register as the ceiling. In this mode a write to compare register 0 takes effect on the next cycle, and that channel drives `pwm_out[0]`.
- R6: `flags[i]` (i = 0, 1, 2) goes high one cycle after the cycle in which `count` equals compare register i.
- R7: `flags[4]` goes high on the same edge at which `count` wraps to zero.
- R8: A set flag stays high until the matching `flag_clr` bit is driven to 1 for a cycle. A flag that is clear stays clear. If a set event and a clear fall in the same cycle, the set wins.
- R9: On the selected edge of `cap_in`, `capture` loads the count and `flags[3]` goes high. With the filter on, the value stored equals c + 5, where c is the count just before the first clock edge that samples the new level.
- R10: With the filter on, a level on `cap_in` that is sampled on fewer than 4 consecutive edges has no effect. A level held for 4 or more edges is accepted.
- R11: When `cap_rising` is 1, only low-to-high edges trigger a capture. When it is 0, only high-to-low edges trigger one. The other edge changes neither `capture` nor `flags[3]`.
- R12: In modes 1 to 5, each enabled channel output is high while `count` is at or below its compare value and low above it, starting from the first wrap. In modes 0, 6 and 7 all outputs are low.
- R13: When `wr_en` is high, `wr_sel` picks the target register: 0, 1 and 2 select the compare registers and 3 selects the capture register. An unshadowed write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Ceiling and waveform mode select |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0..2 compare, 3 capture |
| wr_data | input | CW | Write data |
| cap_in | input | 1 | Capture trigger input |
| cap_rising | input | 1 | 1 = capture on rising edge, 0 = on falling edge |
| flag_clr | input | 5 | Write-one-to-clear for each flag |
| count | output | CW | Current count |
| capture | output | CW | Capture register |
| flags | output | 5 | Sticky flags: [2:0] compare, [3] capture, [4] wrap |
| pwm_out | output | 3 | Waveform output of each compare channel |

## Verification
The assertions assume three things about the inputs. `rst` is held for at least one edge. `mode` stays fixed for at least one cycle before any waveform output is judged. `cap_in` is only sampled on clock edges. The stimulus meets these: it changes every input half a period away from the rising edge, and it selects the mode while reset is active. It changes the ceiling only through writes, never by switching modes while the counter runs. The capture tests run in the full-range mode from a small count, so no wrap falls inside the latency window that the expected values are computed over.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [2:0] {
    TM_FREE     = 3'd0,
    TM_FIX8     = 3'd1,
    TM_FIX9     = 3'd2,
    TM_FIX10    = 3'd3,
    TM_CEIL_A   = 3'd4,
    TM_CEIL_CAP = 3'd5,
    TM_RSV6     = 3'd6,
    TM_RSV7     = 3'd7
  } tmr_mode_e;

  localparam int NCH      = 3;
  localparam int NFLAG    = 5;
  localparam int FLAG_CAP = 3;
  localparam int FLAG_OVF = 4;
endpackage

// File: rtl/tmr_ceiling.sv
`timescale 1ns/1ps
module tmr_ceiling
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  tmr_mode_e        mode,
  input  logic [CW-1:0]    ocr_a,
  input  logic [CW-1:0]    icr,
  output logic [CW-1:0]    top,
  output logic             pwm_mode
);
  localparam logic [CW-1:0] TOP8  = CW'((1 << 8) - 1);
  localparam logic [CW-1:0] TOP9  = CW'((1 << 9) - 1);
  localparam logic [CW-1:0] TOP10 = CW'((1 << 10) - 1);

  always_comb begin
    pwm_mode = 1'b1;
    unique case (mode)
      TM_FIX8:     top = TOP8;
      TM_FIX9:     top = TOP9;
      TM_FIX10:    top = TOP10;
      TM_CEIL_A:   top = ocr_a;
      TM_CEIL_CAP: top = icr;
      default: begin
        top      = '1;
        pwm_mode = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tmr_cmp_chan.sv
`timescale 1ns/1ps
module tmr_cmp_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          shadowed,
  input  logic          wrap,
  input  logic          match,
  input  logic          pwm_en,
  output logic [CW-1:0] ocr,
  output logic          pwm
);
  logic [CW-1:0] shadow_q;
  logic [CW-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (wr) shadow_q <= wdata;
      if (!shadowed && wr)     act_q <= wdata;
      else if (shadowed && wrap) act_q <= shadow_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pwm_en) pwm <= 1'b0;
    else if (wrap)      pwm <= 1'b1;
    else if (match)     pwm <= 1'b0;
  end

  assign ocr = act_q;
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture #(
  parameter int FILT_EN  = 1,
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  localparam int RW = $clog2(FILT_LEN + 1);

  logic s1_q;
  logic flt;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      prev_q <= flt;
    end
  end

  generate
    if (FILT_EN != 0) begin : g_filt
      logic [RW-1:0] run_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          run_q <= '0;
          flt   <= 1'b0;
        end else if (s1_q != flt) begin
          if (run_q == RW'(FILT_LEN - 1)) begin
            flt   <= s1_q;
            run_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end else begin
          run_q <= '0;
        end
      end
    end else begin : g_raw
      assign flt = s1_q;
    end
  endgenerate

  assign hit = (flt != prev_q) && (flt == rise_sel);
endmodule

// File: rtl/cntr_ceiling_timer.sv
`timescale 1ns/1ps
module cntr_ceiling_timer
  import tmr_pkg::*;
#(
  parameter int CW       = 16,
  parameter int FILT_EN  = 1,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CW-1:0]    wr_data,
  input  logic             cap_in,
  input  logic             cap_rising,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    capture,
  output logic [NFLAG-1:0] flags,
  output logic [NCH-1:0]   pwm_out
);
  tmr_mode_e         mode_e;
  logic [CW-1:0]     top_val;
  logic              pwm_mode;
  logic              wrap;
  logic              cap_hit;
  logic [CW-1:0]     chan_ocr [NCH];
  logic [NCH-1:0]    cmp_hit;
  logic [NFLAG-1:0]  flag_set;

  assign mode_e = tmr_mode_e'(mode);
  assign wrap   = (count >= top_val);

  tmr_ceiling #(.CW(CW)) u_ceil (
    .mode     (mode_e),
    .ocr_a    (chan_ocr[0]),
    .icr      (capture),
    .top      (top_val),
    .pwm_mode (pwm_mode)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic is_ceil;
      assign is_ceil    = (i == 0) && (mode_e == TM_CEIL_A);
      assign cmp_hit[i] = (count == chan_ocr[i]);
      tmr_cmp_chan #(.CW(CW)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_en && (wr_sel == 2'(i))),
        .wdata    (wr_data),
        .shadowed (is_ceil),
        .wrap     (wrap),
        .match    (cmp_hit[i]),
        .pwm_en   (pwm_mode && !is_ceil),
        .ocr      (chan_ocr[i]),
        .pwm      (pwm_out[i])
      );
    end
  endgenerate

  tmr_capture #(.FILT_EN(FILT_EN), .FILT_LEN(FILT_LEN)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .pin      (cap_in),
    .rise_sel (cap_rising),
    .hit      (cap_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (wrap) count <= '0;
    else           count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         capture <= '0;
    else if (cap_hit)                capture <= count;
    else if (wr_en && wr_sel == 2'd3) capture <= wr_data;
  end

  assign flag_set = {wrap, cap_hit, cmp_hit};

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~flag_clr) | flag_set;
  end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    mode,
  input logic [4:0]    flag_clr,
  input logic [CW-1:0] count,
  input logic [CW-1:0] top,
  input logic [4:0]    flags,
  input logic [2:0]    pwm_out
);
  // R2: a nonzero count is always the previous count plus one
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |-> (count == $past(count) + CW'(1)));

  // R2: a return to zero outside reset only comes from a count at or above the ceiling
  p_wrap_from_top_r2: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !$past(rst)) |-> ($past(count) >= $past(top)));

  // R7: the wrap flag accompanies every wrap
  p_ovf_on_bottom_r7: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !$past(rst)) |-> flags[4]);

  // R8: a flag stays set unless its clear bit was driven
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((($past(flags) & ~$past(flag_clr)) & ~flags) == 5'd0));

  // R4: channel 0 produces no waveform while it sets the ceiling
  p_ceil_a_no_pwm_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 3'd4) |-> !pwm_out[0]);

  // R12: full-range modes produce no waveform
  p_free_no_pwm_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 3'd0 || $past(mode) >= 3'd6)) |-> (pwm_out == 3'b000));
endmodule

bind cntr_ceiling_timer tmr_checker #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .flag_clr (flag_clr),
  .count    (count),
  .top      (top_val),
  .flags    (flags),
  .pwm_out  (pwm_out)
);

// File: tb/test_cntr_ceiling_timer.sv
`timescale 1ns/1ps
module test_cntr_ceiling_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode = 3'd0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        cap_in = 1'b0;
  logic        cap_rising = 1'b1;
  logic [4:0]  flag_clr = 5'd0;
  logic [15:0] count;
  logic [15:0] capture;
  logic [4:0]  flags;
  logic [2:0]  pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cntr_ceiling_timer i_cntr_ceiling_timer (
    .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cap_in(cap_in), .cap_rising(cap_rising),
    .flag_clr(flag_clr), .count(count), .capture(capture), .flags(flags),
    .pwm_out(pwm_out)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [2:0] m);
    rst = 1'b1; mode = m; flag_clr = 5'd0; wr_en = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic write_reg(logic [1:0] sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 5'h1F;
    step(1);
    flag_clr = 5'd0;
  endtask

  task automatic measure_top(output logic [15:0] seen);
    logic [15:0] prev;
    seen = 16'hDEAD;
    for (int g = 0; g < 70000; g++) begin
      prev = count;
      step(1);
      if (count < prev) begin
        seen = prev;
        break;
      end
    end
  endtask

  task automatic wait_count(logic [15:0] v);
    for (int g = 0; g < 70000; g++) begin
      if (count == v) break;
      step(1);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; mode = 3'd0;
    step(3);
    check("R1", "count in reset", count, 0);
    check("R1", "flags in reset", flags, 0);
    check("R1", "pwm in reset", pwm_out, 0);
    check("R1", "capture in reset", capture, 0);
    rst = 1'b0;
    step(1);
    check("R2", "first count", count, 1);
    check("R6", "zero compare flags", flags, 5'b00111);
  endtask

  task automatic t_free_step();
    logic [15:0] prev;
    int bad = 0;
    for (int k = 0; k < 10; k++) begin
      prev = count;
      step(1);
      if (count != prev + 16'd1 || pwm_out != 3'd0) bad++;
    end
    check("R2", "free increments / R12 outputs low", bad, 0);
  endtask

  task automatic t_tops();
    logic [15:0] seen;
    logic [2:0]  modes [4] = '{3'd1, 3'd2, 3'd3, 3'd0};
    logic [15:0] exps  [4] = '{16'h00FF, 16'h01FF, 16'h03FF, 16'hFFFF};
    for (int k = 0; k < 4; k++) begin
      do_reset(modes[k]);
      measure_top(seen);
      check("R3", "ceiling for mode", seen, exps[k]);
      check("R7", "count zero after wrap", count, 0);
      check("R7", "wrap flag", flags[4], 1);
    end
    do_reset(3'd6);
    step(1100);
    check("R3", "mode 6 passes 0x3FF", count, 1100);
  endtask

  task automatic t_flags();
    do_reset(3'd0);
    step(1);
    clear_flags();
    check("R8", "flags cleared", flags, 0);
    write_reg(2'd1, 16'd50);
    wait_count(16'd50);
    check("R6", "flag 1 before match", flags[1], 0);
    step(1);
    check("R6", "flag 1 after match (R13 write)", flags[1], 1);
    step(5);
    check("R8", "flag 1 sticky", flags[1], 1);
    flag_clr = 5'b00010;
    step(1);
    flag_clr = 5'd0;
    check("R8", "flag 1 cleared", flags[1], 0);
  endtask

  task automatic t_pwm_fixed();
    logic [15:0] ref_v [3] = '{16'h40, 16'h80, 16'hFF};
    int bad = 0;
    do_reset(3'd1);
    for (int i = 0; i < 3; i++) write_reg(2'(i), ref_v[i]);
    step(1);
    wait_count(16'd0);
    for (int k = 0; k < 256; k++) begin
      for (int i = 0; i < 3; i++)
        if (pwm_out[i] !== (count <= ref_v[i])) bad++;
      step(1);
    end
    check("R12", "waveforms in mode 1", bad, 0);
  endtask

  task automatic t_ceil_a();
    logic [15:0] seen;
    int bad = 0;
    do_reset(3'd4);
    write_reg(2'd0, 16'd20);
    write_reg(2'd1, 16'd6);
    measure_top(seen);
    check("R4", "shadowed ceiling first", seen, 20);
    for (int k = 0; k < 21; k++) begin
      if (pwm_out[1] !== (count <= 16'd6) || pwm_out[0] !== 1'b0) bad++;
      step(1);
    end
    check("R12", "channel 1 in mode 4, channel 0 low (R4)", bad, 0);
    wait_count(16'd5);
    write_reg(2'd0, 16'd8);
    measure_top(seen);
    check("R4", "old ceiling kept until wrap", seen, 20);
    measure_top(seen);
    check("R4", "new ceiling after wrap", seen, 8);
    check("R4", "channel 0 output", pwm_out[0], 0);
  endtask

  task automatic t_ceil_cap();
    logic [15:0] seen;
    int bad = 0;
    do_reset(3'd5);
    write_reg(2'd3, 16'd30);
    write_reg(2'd0, 16'd10);
    measure_top(seen);
    check("R5", "capture register ceiling", seen, 30);
    for (int k = 0; k < 31; k++) begin
      if (pwm_out[0] !== (count <= 16'd10)) bad++;
      step(1);
    end
    check("R5", "channel 0 waveform", bad, 0);
    bad = 0;
    write_reg(2'd0, 16'd25);
    for (int k = 0; k < 30; k++) begin
      if (pwm_out[0] !== (count <= 16'd25)) bad++;
      step(1);
    end
    check("R5", "immediate write R13", bad, 0);
  endtask

  task automatic t_capture();
    logic [15:0] c0;
    logic [15:0] saved;
    do_reset(3'd0);
    cap_rising = 1'b1; cap_in = 1'b0;
    step(10);
    c0 = count; cap_in = 1'b1;
    step(8);
    check("R9", "captured count", capture, c0 + 16'd5);
    check("R9", "capture flag", flags[3], 1);
    clear_flags();
    saved = capture;
    cap_in = 1'b0;
    step(8);
    check("R11", "falling ignored flag", flags[3], 0);
    check("R11", "falling ignored value", capture, saved);
    cap_in = 1'b1; step(3); cap_in = 1'b0;
    step(8);
    check("R10", "short pulse flag", flags[3], 0);
    check("R10", "short pulse value", capture, saved);
    c0 = count; cap_in = 1'b1; step(4); cap_in = 1'b0;
    step(8);
    check("R10", "4-cycle pulse accepted", capture, c0 + 16'd5);
    cap_rising = 1'b0;
    clear_flags();
    saved = capture;
    cap_in = 1'b1;
    step(8);
    check("R11", "rising ignored flag", flags[3], 0);
    check("R11", "rising ignored value", capture, saved);
    c0 = count; cap_in = 1'b0;
    step(8);
    check("R11", "falling capture", capture, c0 + 16'd5);
    check("R11", "falling flag", flags[3], 1);
  endtask

  initial begin
    step(1);
    t_reset();
    t_free_step();
    t_tops();
    t_flags();
    t_pwm_fixed();
    t_ceil_a();
    t_ceil_cap();
    t_capture();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule